// File: doc/BRIEF.md
# I2C Slave Word-Register Interface

This block is a slave-only two-wire serial interface that lets a bus master read and write a bank of 16-bit registers. The master drives the clock line and creates every START and STOP; the block samples both bus lines with its own much faster system clock, recognises START, Repeated START and STOP, and answers only to one hard-wired 7-bit address. It never drives a line high. The data line is pulled low through a single open-drain enable output.

In a write transaction the first data byte after the address sets an 8-bit register pointer. Each following pair of bytes forms one 16-bit word, low byte first. The word is committed to the register under the pointer when its high byte arrives, and the pointer then advances by one. A read transaction returns words from the current pointer in the same low-then-high byte order, MSB first inside each byte. The usual way to read is a write of the pointer, a Repeated START, and then the read address. The register contents are also presented as a flat vector for the rest of the chip.

The system clock must run at least 20 times faster than the bus clock. Bus clock rates up to 400 kHz need no setting.

Top module: `i2c_word_slave`

## Requirements
- R1: During and right after reset `sda_oe` is 0. Register k holds the value {8'hA0+k, 8'h50+k}, where the high byte is bits 15:8.
- R2: An address byte whose upper seven bits equal `SLAVE_ADDR` (default 7'b0110110) is acknowledged by holding `sda_oe` high during the ninth clock. Any other address gets no acknowledge, and `sda_oe` stays 0 for the rest of that transaction.
- R3: In a write transaction (R/W bit, the address byte's bit 0, equal to 0) every data byte is acknowledged, and the first data byte loads the register pointer.
- R4: After the pointer byte, written bytes pair up low byte then high byte. The register at the pointer changes only when the high byte has been received, and the pointer then increments by one.
- R5: A low byte that is followed by STOP or Repeated START before its high byte leaves every register unchanged.
- R6: In a read transaction (R/W bit 1) the slave sends bytes MSB first, starting with the low byte of the word at the pointer and then its high byte. The pointer increments after each high byte.
- R7: When the master answers a read byte with NACK, the slave releases the data line and drives nothing until the next START.
- R8: A Repeated START ends the current transaction and begins a new address phase without a STOP. The pointer is kept, and a read that follows begins at the low byte.
- R9: For pointer values of `NUM_REGS` or more, written words are discarded and read bytes are 8'h00.
- R10: `sda_oe` changes only while the bus clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20x the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| regs_flat | output | NUM_REGS*16 | Register bank contents, register k at bits 16k+15:16k |

## Verification
The bench builds the block with `NUM_REGS` set to 4 and keeps the default address and two synchronizer stages. With only four registers, one sweep can write and read back every word. Pointer values past the bank, such as 8'hF0, can then be used to check that writes are discarded and reads return zero. The address match is swept over all 128 seven-bit values. This also confirms that a mismatched address leaves the following byte unacknowledged.

// File: rtl/i2cws_pkg.sv
package i2cws_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int PTR_W  = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_WAIT
    } i2cws_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } i2cws_bus_ev_t;

    typedef struct packed {
        logic              req;
        logic [PTR_W-1:0]  idx;
        logic [WORD_W-1:0] data;
    } i2cws_wr_t;

    function automatic logic [WORD_W-1:0] reset_word(input int unsigned k);
        return {8'hA0 + 8'(k), 8'h50 + 8'(k)};
    endfunction

    function automatic logic addr_hit(input logic [BYTE_W-1:0] frame,
                                      input logic [6:0] addr);
        return frame[BYTE_W-1:1] == addr;
    endfunction

endpackage

// File: rtl/i2cws_sampler.sv
module i2cws_sampler
    import i2cws_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    output i2cws_bus_ev_t ev
);

    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_d;
    logic                   sda_d;
    logic                   scl_s;
    logic                   sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    assign scl_s = scl_sh[SYNC_STAGES-1];
    assign sda_s = sda_sh[SYNC_STAGES-1];

    always_comb begin
        ev.scl   = scl_s;
        ev.sda   = sda_s;
        ev.rise  = scl_s & ~scl_d;
        ev.fall  = ~scl_s & scl_d;
        ev.start = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/i2cws_regfile.sv
module i2cws_regfile
    import i2cws_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  i2cws_wr_t                  wr,
    input  logic [PTR_W-1:0]           rd_idx,
    output logic [WORD_W-1:0]          rd_data,
    output logic [NUM_REGS*WORD_W-1:0] regs_flat
);

    generate
        for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
            logic [WORD_W-1:0] word_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    word_q <= reset_word(k);
                end else if (wr.req && wr.idx == PTR_W'(k)) begin
                    word_q <= wr.data;
                end
            end
            assign regs_flat[k*WORD_W +: WORD_W] = word_q;
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_idx == PTR_W'(k)) begin
                rd_data = regs_flat[k*WORD_W +: WORD_W];
            end
        end
    end

endmodule

// File: rtl/i2cws_ctrl.sv
module i2cws_ctrl
    import i2cws_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'b0110110
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [WORD_W-1:0] rd_data,
    output logic [PTR_W-1:0]  ptr_o,
    output i2cws_wr_t         wr_o,
    output logic              sda_oe
);

    i2cws_state_e      state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] hold_lo;
    logic [WORD_W-1:0] snap;
    logic [PTR_W-1:0]  ptr;
    logic              hi_sel;
    logic              ptr_next;
    logic              rw_q;
    logic              nack_q;
    logic              oe_q;
    i2cws_wr_t         wr_q;
    logic [BYTE_W-1:0] next_tx;
    logic              byte_done;

    assign next_tx   = hi_sel ? snap[WORD_W-1:BYTE_W] : rd_data[BYTE_W-1:0];
    assign byte_done = scl_fall && (cnt == CNT_W'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            hold_lo  <= '0;
            snap     <= '0;
            ptr      <= '0;
            hi_sel   <= 1'b0;
            ptr_next <= 1'b0;
            rw_q     <= 1'b0;
            nack_q   <= 1'b0;
            oe_q     <= 1'b0;
            wr_q     <= '0;
        end else begin
            wr_q.req <= 1'b0;
            if (bus_start) begin
                state    <= ST_ADDR;
                cnt      <= '0;
                oe_q     <= 1'b0;
                hi_sel   <= 1'b0;
                ptr_next <= 1'b1;
            end else if (bus_stop) begin
                state <= ST_IDLE;
                oe_q  <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + CNT_W'(1);
                        end else if (byte_done) begin
                            if (addr_hit(rx_sh, SLAVE_ADDR)) begin
                                state <= ST_ADDR_ACK;
                                oe_q  <= 1'b1;
                                rw_q  <= rx_sh[0];
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rw_q) begin
                                state <= ST_RD;
                                if (!hi_sel) snap <= rd_data;
                                tx_sh <= next_tx;
                                oe_q  <= ~next_tx[BYTE_W-1];
                            end else begin
                                state <= ST_WR;
                                oe_q  <= 1'b0;
                            end
                        end
                    end
                    ST_WR: begin
                        if (scl_rise) begin
                            rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + CNT_W'(1);
                        end else if (byte_done) begin
                            state <= ST_WR_ACK;
                            oe_q  <= 1'b1;
                            if (ptr_next) begin
                                ptr      <= rx_sh;
                                ptr_next <= 1'b0;
                                hi_sel   <= 1'b0;
                            end else if (!hi_sel) begin
                                hold_lo <= rx_sh;
                                hi_sel  <= 1'b1;
                            end else begin
                                wr_q.req  <= 1'b1;
                                wr_q.idx  <= ptr;
                                wr_q.data <= {rx_sh, hold_lo};
                                ptr       <= ptr + PTR_W'(1);
                                hi_sel    <= 1'b0;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            state <= ST_WR;
                            oe_q  <= 1'b0;
                            cnt   <= '0;
                        end
                    end
                    ST_RD: begin
                        if (scl_rise) begin
                            cnt <= cnt + CNT_W'(1);
                        end else if (byte_done) begin
                            state <= ST_RD_ACK;
                            oe_q  <= 1'b0;
                        end else if (scl_fall) begin
                            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                            oe_q  <= ~tx_sh[BYTE_W-2];
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            nack_q <= sda_s;
                            if (hi_sel) begin
                                ptr    <= ptr + PTR_W'(1);
                                hi_sel <= 1'b0;
                            end else begin
                                hi_sel <= 1'b1;
                            end
                        end else if (scl_fall) begin
                            if (nack_q) begin
                                state <= ST_WAIT;
                            end else begin
                                state <= ST_RD;
                                cnt   <= '0;
                                if (!hi_sel) snap <= rd_data;
                                tx_sh <= next_tx;
                                oe_q  <= ~next_tx[BYTE_W-1];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ptr_o  = ptr;
    assign wr_o   = wr_q;
    assign sda_oe = oe_q;

endmodule

// File: rtl/i2c_word_slave.sv
module i2c_word_slave
    import i2cws_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'b0110110,
    parameter int         NUM_REGS    = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe,
    output logic [NUM_REGS*WORD_W-1:0] regs_flat
);

    i2cws_bus_ev_t     ev;
    i2cws_wr_t         wr;
    logic [PTR_W-1:0]  ptr;
    logic [WORD_W-1:0] rd_data;
    logic              scl_s;
    logic              start_p;
    logic              stop_p;
    logic              wr_req;

    i2cws_sampler #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sampler (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    assign scl_s   = ev.scl;
    assign start_p = ev.start;
    assign stop_p  = ev.stop;
    assign wr_req  = wr.req;

    i2cws_ctrl #(
        .SLAVE_ADDR (SLAVE_ADDR)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sda_s     (ev.sda),
        .scl_rise  (ev.rise),
        .scl_fall  (ev.fall),
        .bus_start (start_p),
        .bus_stop  (stop_p),
        .rd_data   (rd_data),
        .ptr_o     (ptr),
        .wr_o      (wr),
        .sda_oe    (sda_oe)
    );

    i2cws_regfile #(
        .NUM_REGS (NUM_REGS)
    ) u_regfile (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .rd_idx    (ptr),
        .rd_data   (rd_data),
        .regs_flat (regs_flat)
    );

endmodule

// File: rtl/i2cws_checker.sv
module i2cws_checker #(
    parameter int NUM_REGS = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   scl_s,
    input logic                   start_p,
    input logic                   stop_p,
    input logic                   wr_req,
    input logic                   sda_oe,
    input logic [NUM_REGS*16-1:0] regs_flat
);

    // R1: the line is released on leaving reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !sda_oe);

    // R4: the bank moves only on a committed word
    p_regs_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_req |=> $stable(regs_flat));

    // R4: a commit follows a clock fall, never a high clock
    p_commit_low_r4: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> !scl_s);

    // R7: a STOP leaves the line released
    p_stop_release_r7: assert property (@(posedge clk) disable iff (rst)
        stop_p |=> !sda_oe);

    // R8: a START or Repeated START leaves the line released
    p_start_release_r8: assert property (@(posedge clk) disable iff (rst)
        start_p |=> !sda_oe);

    // R10: the drive changes only while the clock line is low
    p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

endmodule

bind i2c_word_slave i2cws_checker #(
    .NUM_REGS (NUM_REGS)
) u_i2cws_checker (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .start_p   (start_p),
    .stop_p    (stop_p),
    .wr_req    (wr_req),
    .sda_oe    (sda_oe),
    .regs_flat (regs_flat)
);

// File: tb/test_i2c_word_slave.sv
`timescale 1ns/1ps
module test_i2c_word_slave;

    localparam int NREG = 4;
    localparam int Q    = 8;
    localparam logic [6:0] ADDR = 7'b0110110;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [NREG*16-1:0] regs_flat;
    logic sda_bus;

    int tests = 0;
    int fails = 0;
    int viol = 0;
    logic done = 1'b0;
    logic oe_prev = 1'b0;
    logic [15:0] model [NREG];

    assign sda_bus = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    i2c_word_slave #(
        .NUM_REGS (NREG)
    ) i_i2c_word_slave (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .regs_flat (regs_flat)
    );

    // R10 monitor: drive changes seen while the master holds the clock high
    always @(posedge clk) begin
        if (!rst && (sda_oe !== oe_prev) && scl_m) viol <= viol + 1;
        oe_prev <= sda_oe;
    end

    task automatic chk(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic wr_bit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic rd_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_bus;  tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wr_bit(v[i]);
        rd_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rd_bit(b);
            v[i] = b;
        end
        wr_bit(~give_ack);
    endtask

    function automatic logic [15:0] exp_word(input int p);
        return (p < NREG) ? model[p] : 16'h0000;
    endfunction

    task automatic chk_bank(input string req);
        for (int k = 0; k < NREG; k++)
            chk(regs_flat[k*16 +: 16] == model[k], req,
                32'(regs_flat[k*16 +: 16]), 32'(model[k]));
    endtask

    task automatic set_ptr(input logic [7:0] p);
        logic a;
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        chk(a, "R2 address ack", 32'(a), 1);
        send_byte(p, a);
        chk(a, "R3 pointer byte ack", 32'(a), 1);
    endtask

    // Pointer write, Repeated START, read n words
    task automatic read_words(input int p, input int n, input string req);
        logic a;
        logic [7:0] lo;
        logic [7:0] hi;
        logic [15:0] e;
        set_ptr(8'(p));
        bus_start();
        send_byte({ADDR, 1'b1}, a);
        chk(a, "R8 read address after repeated start", 32'(a), 1);
        for (int k = 0; k < n; k++) begin
            e = exp_word((p + k) % 256);
            recv_byte(lo, 1'b1);
            recv_byte(hi, k != n - 1);
            chk(lo == e[7:0], req, 32'(lo), 32'(e[7:0]));
            chk(hi == e[15:8], req, 32'(hi), 32'(e[15:8]));
        end
        bus_stop();
    endtask

    task automatic write_words(input int p, input int n, input logic [15:0] base,
                               input logic [15:0] step);
        logic a;
        logic [15:0] w;
        set_ptr(8'(p));
        for (int k = 0; k < n; k++) begin
            w = base + 16'(k) * step;
            send_byte(w[7:0], a);
            chk(a, "R3 low byte ack", 32'(a), 1);
            send_byte(w[15:8], a);
            chk(a, "R3 high byte ack", 32'(a), 1);
            if (p + k < NREG) model[p + k] = w;
        end
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] v;
        for (int k = 0; k < NREG; k++) model[k] = {8'hA0 + 8'(k), 8'h50 + 8'(k)};
        tick(6);
        chk(sda_oe == 1'b0, "R1 sda_oe in reset", 32'(sda_oe), 0);
        rst = 1'b0;
        tick(4);
        chk(sda_oe == 1'b0, "R1 sda_oe after reset", 32'(sda_oe), 0);
        chk_bank("R1 reset values");

        // R2: sweep every 7-bit address with a write
        for (int ad = 0; ad < 128; ad++) begin
            bus_start();
            send_byte({7'(ad), 1'b0}, a);
            chk(a == (7'(ad) == ADDR), "R2 address match", 32'(a), 32'(7'(ad) == ADDR));
            if (7'(ad) != ADDR) begin
                send_byte(8'h00, a);
                chk(a == 1'b0, "R2 ignored after mismatch", 32'(a), 0);
            end
            bus_stop();
        end
        chk_bank("R2 bank untouched by sweep");

        // R2: mismatched read returns released line
        bus_start();
        send_byte({ADDR ^ 7'h01, 1'b1}, a);
        chk(a == 1'b0, "R2 read mismatch no ack", 32'(a), 0);
        recv_byte(v, 1'b0);
        chk(v == 8'hFF, "R2 mismatched read line released", 32'(v), 32'hFF);
        bus_stop();

        // R3 R4: two words from pointer 1
        write_words(1, 2, 16'hBEEF, 16'h5345);
        chk_bank("R4 words written low then high with increment");

        // R5: low byte only, then STOP
        set_ptr(8'd3);
        send_byte(8'h77, a);
        chk_bank("R4 no change after low byte alone");
        bus_stop();
        chk_bank("R5 partial word discarded on stop");

        // R5: low byte only, then Repeated START
        set_ptr(8'd0);
        send_byte(8'h11, a);
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        bus_stop();
        chk_bank("R5 partial word discarded on repeated start");

        // R6 R8: read all words from pointer 0
        read_words(0, NREG, "R6 sequential read");

        // R7: NACK after the low byte, then clock a byte
        set_ptr(8'd2);
        bus_start();
        send_byte({ADDR, 1'b1}, a);
        recv_byte(v, 1'b0);
        chk(v == model[2][7:0], "R6 low byte first", 32'(v), 32'(model[2][7:0]));
        recv_byte(v, 1'b0);
        chk(v == 8'hFF, "R7 released after nack", 32'(v), 32'hFF);
        chk(sda_oe == 1'b0, "R7 sda_oe after nack", 32'(sda_oe), 0);
        // R8: Repeated START read keeps pointer, restarts at low byte
        bus_start();
        send_byte({ADDR, 1'b1}, a);
        chk(a, "R8 repeated start address ack", 32'(a), 1);
        recv_byte(v, 1'b1);
        chk(v == model[2][7:0], "R8 pointer kept low byte", 32'(v), 32'(model[2][7:0]));
        recv_byte(v, 1'b0);
        chk(v == model[2][15:8], "R8 pointer kept high byte", 32'(v), 32'(model[2][15:8]));
        bus_stop();

        // R9: out-of-range pointer
        write_words(8'hF0, 1, 16'hAAAA, 16'h0000);
        chk_bank("R9 out of range write discarded");
        read_words(8'hF0, 2, "R9 out of range read zero");

        // R4 R6: sweep whole bank with a computed pattern
        write_words(0, NREG, 16'h1357, 16'h2468);
        chk_bank("R4 full bank sweep");
        read_words(0, NREG, "R6 full bank readback");
        read_words(NREG - 1, 2, "R9 read crossing bank end");

        chk(viol == 0, "R10 sda_oe change while scl high", 32'(viol), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule